// File: doc/BRIEF.md
# Multiplexed external bus controller

This block runs external memory cycles for a small processor core. The bus reuses its data lines to carry the upper part of each address. The core hands over one request at a time through a valid/ready handshake. A request is a code fetch, a data read, or a write with per-byte enables, together with an address and write data. The controller then plays the cycle out on the pins. First comes an address phase, during which an active-high latch-enable output lets an external transparent latch capture the upper address from the shared lines. The matching active-low strobe follows. At the end the core gets a one-clock completion pulse, carrying the read data for fetches and reads.

The lowest address lines are not shared. They are driven directly for the whole cycle. Each cycle type has its own programmable length, set from configuration inputs counted in clocks. A slow device can also stretch a cycle through a stall input, which passes through a synchronizer before it is used. A boot-mode pin is captured while reset is held. When the captured value is high, code fetches below a fixed on-chip limit are sent to a one-clock internal port instead of the external bus.

Top module: `mxbus_ctrl`

## Requirements
- R1: While reset is held and in the first idle cycle after it: latch enable low, all four strobes high, shared-line output enable low, ready high, completion low, low address lines zero.
- R2: A request is taken on a clock edge where valid and ready are both high. Ready stays low until the completion pulse. The completion pulse lasts exactly one clock, and ready is high in that same clock.
- R3: For an external request, latch enable is high for max(ale_cfg,1) clocks, starting the clock after acceptance. During those clocks the shared lines are driven with address bits [AW-1:LOW_W] and no strobe is active. The strobe starts in the clock right after latch enable falls.
- R4: The request kind code selects the strobe: 0 fetch asserts the fetch strobe, 1 read asserts the read strobe, and 2 write asserts the low-byte strobe when byte enable bit 0 is set and the high-byte strobe when bit 1 is set, both in the same clocks. No two kinds are ever active together.
- R5: With the stall input low, the strobe lasts max(cfg,1) clocks. The cfg value is the code, read or write count, chosen by the request kind. Completion follows in the next clock, so it arrives A+S+1 clocks after acceptance.
- R6: During a write strobe the shared lines are driven with the write data. During a fetch or read strobe they are released, with output enable low.
- R7: For a fetch or read, the shared-line input is sampled on the last strobe clock. That value appears on the read-data output with the completion pulse.
- R8: The low address lines carry address bits [LOW_W-1:0] from the first latch-enable clock through completion. They keep that value while idle, until the next external request.
- R9: The stall input passes through a two-flop synchronizer and is looked at only on the last programmed strobe clock. While it is high there, the strobe is held. If the pin is seen low at clock edge k, the strobe is still active after edges k and k+1, and completion is high after edge k+2.
- R10: The boot-mode pin is captured on every clock while reset is high. The value from the last reset clock is kept until the next reset. Later changes on the pin have no effect.
- R11: With the captured boot mode at 0, every fetch goes external. With it at 1, a fetch whose address is below ON_CHIP_LIMIT goes internal instead: the internal-read pulse is high with the address in the clock after acceptance, no latch enable or strobe occurs, and completion comes in the next clock with the internal read data sampled. Fetches at or above the limit, and all reads and writes, go external.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| req_kind_i | input | 2 | 0 fetch, 1 read, 2 write |
| req_addr_i | input | AW | Byte address |
| req_wdata_i | input | DW | Write data |
| req_be_i | input | 2 | Write byte enables, bit 0 low byte |
| resp_valid_o | output | 1 | One-clock completion pulse |
| resp_rdata_o | output | DW | Read data of the completed fetch or read |
| cfg_ale_clks_i | input | CW | Address-phase length in clocks, 0 treated as 1 |
| cfg_code_clks_i | input | CW | Fetch strobe length |
| cfg_rd_clks_i | input | CW | Read strobe length |
| cfg_wr_clks_i | input | CW | Write strobe length |
| boot_pin_i | input | 1 | Boot-mode pin, captured during reset |
| int_rd_o | output | 1 | Internal code read pulse |
| int_addr_o | output | AW | Internal code read address |
| int_rdata_i | input | DW | Internal code read data |
| bus_alatch_o | output | 1 | Address latch enable, active high |
| bus_alo_o | output | LOW_W | Directly driven low address lines |
| bus_ad_o | output | DW | Shared address/data lines, output value |
| bus_ad_oe_o | output | 1 | Shared lines output enable |
| bus_ad_i | input | DW | Shared address/data lines, input value |
| bus_stall_i | input | 1 | Asynchronous stall request, active high |
| bus_fetch_n_o | output | 1 | Code fetch strobe, active low |
| bus_read_n_o | output | 1 | Data read strobe, active low |
| bus_wlo_n_o | output | 1 | Low byte write strobe, active low |
| bus_whi_n_o | output | 1 | High byte write strobe, active low |

## Verification
Counting from the acceptance edge, latch enable is due in clocks 1 to A, the strobe in clocks A+1 to A+S, and completion in clock A+S+1 for external cycles. For internal fetches the internal-read pulse is due in clock 1 and completion in clock 2. The bench drives every input on the falling edge and samples every output on the following falling edge, so each clock after acceptance is checked against the phase that clock should be in. Stall release is checked to the edge: the strobe must still be active one and two clocks after the release edge, and completion must come on the third. Boot-mode capture is checked by changing the pin right after reset and then looking at where fetches go.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2
    } xfer_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_STRB = 2'd2,
        PH_INT  = 2'd3
    } phase_e;

    // Active-high internal view of the four bus strobes.
    typedef struct packed {
        logic code;
        logic rd;
        logic wlo;
        logic whi;
    } strobe_t;

    function automatic strobe_t strobe_for(input xfer_kind_e kind, input logic [1:0] be);
        strobe_t s;
        s = '0;
        case (kind)
            KIND_FETCH: s.code = 1'b1;
            KIND_WRITE: begin
                s.wlo = be[0];
                s.whi = be[1];
            end
            default:    s.rd = 1'b1;
        endcase
        return s;
    endfunction

    function automatic logic is_write(input xfer_kind_e kind);
        return kind == KIND_WRITE;
    endfunction

endpackage

// File: rtl/mxbus_sync.sv
module mxbus_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q <= '0;
                else       chain_q <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q <= '0;
                else       chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mxbus_boot_latch.sv
module mxbus_boot_latch (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pin_i,
    output logic boot_o
);
    logic boot_q;

    // Transparent while reset is held; the last reset clock wins.
    always_ff @(posedge clk_i) begin
        if (rst_i) boot_q <= pin_i;
    end

    assign boot_o = boot_q;
endmodule

// File: rtl/mxbus_len_sel.sv
module mxbus_len_sel import mxbus_pkg::*; #(
    parameter int unsigned CW = 4
) (
    input  xfer_kind_e      kind_i,
    input  logic [CW-1:0]   ale_cfg_i,
    input  logic [CW-1:0]   code_cfg_i,
    input  logic [CW-1:0]   rd_cfg_i,
    input  logic [CW-1:0]   wr_cfg_i,
    output logic [CW-1:0]   ale_len_o,
    output logic [CW-1:0]   strb_len_o
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] raw_strb;

    always_comb begin
        case (kind_i)
            KIND_FETCH: raw_strb = code_cfg_i;
            KIND_WRITE: raw_strb = wr_cfg_i;
            default:    raw_strb = rd_cfg_i;
        endcase
    end

    assign ale_len_o  = (ale_cfg_i == '0) ? ONE : ale_cfg_i;
    assign strb_len_o = (raw_strb  == '0) ? ONE : raw_strb;
endmodule

// File: rtl/mxbus_seq.sv
module mxbus_seq import mxbus_pkg::*; #(
    parameter int unsigned LOW_W         = 4,
    parameter int unsigned DW            = 16,
    parameter int unsigned CW            = 4,
    parameter int unsigned ON_CHIP_LIMIT = 32'h0000_4000,
    localparam int unsigned AW           = DW + LOW_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              boot_i,
    input  logic              stall_i,
    input  logic              req_valid_i,
    input  xfer_kind_e        req_kind_i,
    input  logic [AW-1:0]     req_addr_i,
    input  logic [DW-1:0]     req_wdata_i,
    input  logic [1:0]        req_be_i,
    input  logic [CW-1:0]     ale_len_i,
    input  logic [CW-1:0]     strb_len_i,
    input  logic [DW-1:0]     ad_i,
    input  logic [DW-1:0]     int_rdata_i,
    output xfer_kind_e        kind_o,
    output logic              ready_o,
    output logic              resp_valid_o,
    output logic [DW-1:0]     resp_rdata_o,
    output logic              int_rd_o,
    output logic [AW-1:0]     int_addr_o,
    output logic              alatch_o,
    output logic [LOW_W-1:0]  alo_o,
    output logic [DW-1:0]     ad_o,
    output logic              ad_oe_o,
    output strobe_t           strobe_o
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    phase_e            phase_q;
    xfer_kind_e        kind_q;
    logic [1:0]        be_q;
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     wdata_q;
    logic [CW-1:0]     cnt_q;
    logic [DW-1:0]     rdata_q;
    logic              done_q;
    logic [LOW_W-1:0]  lo_q;
    logic              route_int;
    logic              last_clk;

    assign route_int = (req_kind_i == KIND_FETCH) && boot_i
                     && (32'(req_addr_i) < ON_CHIP_LIMIT);
    assign last_clk  = (cnt_q == ONE);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= PH_IDLE;
            kind_q  <= KIND_READ;
            be_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            cnt_q   <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
            lo_q    <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (req_valid_i) begin
                        kind_q  <= req_kind_i;
                        be_q    <= req_be_i;
                        addr_q  <= req_addr_i;
                        wdata_q <= req_wdata_i;
                        if (route_int) begin
                            phase_q <= PH_INT;
                        end else begin
                            phase_q <= PH_ADDR;
                            cnt_q   <= ale_len_i;
                            lo_q    <= req_addr_i[LOW_W-1:0];
                        end
                    end
                end
                PH_ADDR: begin
                    if (last_clk) begin
                        phase_q <= PH_STRB;
                        cnt_q   <= strb_len_i;
                    end else begin
                        cnt_q <= cnt_q - ONE;
                    end
                end
                PH_STRB: begin
                    if (!last_clk) begin
                        cnt_q <= cnt_q - ONE;
                    end else if (!stall_i) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                        if (!is_write(kind_q)) rdata_q <= ad_i;
                    end
                end
                PH_INT: begin
                    phase_q <= PH_IDLE;
                    done_q  <= 1'b1;
                    rdata_q <= int_rdata_i;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        alatch_o = (phase_q == PH_ADDR);
        strobe_o = '0;
        if (phase_q == PH_STRB) strobe_o = strobe_for(kind_q, be_q);
        ad_oe_o  = alatch_o || ((phase_q == PH_STRB) && is_write(kind_q));
        ad_o     = alatch_o ? addr_q[AW-1:LOW_W] : wdata_q;
    end

    assign kind_o       = kind_q;
    assign ready_o      = (phase_q == PH_IDLE);
    assign resp_valid_o = done_q;
    assign resp_rdata_o = rdata_q;
    assign int_rd_o     = (phase_q == PH_INT);
    assign int_addr_o   = addr_q;
    assign alo_o        = lo_q;
endmodule

// File: rtl/mxbus_ctrl.sv
module mxbus_ctrl import mxbus_pkg::*; #(
    parameter int unsigned LOW_W         = 4,
    parameter int unsigned DW            = 16,
    parameter int unsigned CW            = 4,
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned ON_CHIP_LIMIT = 32'h0000_4000,
    localparam int unsigned AW           = DW + LOW_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [1:0]        req_kind_i,
    input  logic [AW-1:0]     req_addr_i,
    input  logic [DW-1:0]     req_wdata_i,
    input  logic [1:0]        req_be_i,
    output logic              resp_valid_o,
    output logic [DW-1:0]     resp_rdata_o,
    input  logic [CW-1:0]     cfg_ale_clks_i,
    input  logic [CW-1:0]     cfg_code_clks_i,
    input  logic [CW-1:0]     cfg_rd_clks_i,
    input  logic [CW-1:0]     cfg_wr_clks_i,
    input  logic              boot_pin_i,
    output logic              int_rd_o,
    output logic [AW-1:0]     int_addr_o,
    input  logic [DW-1:0]     int_rdata_i,
    output logic              bus_alatch_o,
    output logic [LOW_W-1:0]  bus_alo_o,
    output logic [DW-1:0]     bus_ad_o,
    output logic              bus_ad_oe_o,
    input  logic [DW-1:0]     bus_ad_i,
    input  logic              bus_stall_i,
    output logic              bus_fetch_n_o,
    output logic              bus_read_n_o,
    output logic              bus_wlo_n_o,
    output logic              bus_whi_n_o
);
    logic          boot_q;
    logic          stall_s;
    xfer_kind_e    cur_kind;
    logic [CW-1:0] ale_len;
    logic [CW-1:0] strb_len;
    strobe_t       stb;

    mxbus_boot_latch u_boot (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .pin_i  (boot_pin_i),
        .boot_o (boot_q)
    );

    mxbus_sync #(.STAGES(SYNC_STAGES)) u_stall_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (bus_stall_i),
        .q_o   (stall_s)
    );

    mxbus_len_sel #(.CW(CW)) u_len (
        .kind_i     (cur_kind),
        .ale_cfg_i  (cfg_ale_clks_i),
        .code_cfg_i (cfg_code_clks_i),
        .rd_cfg_i   (cfg_rd_clks_i),
        .wr_cfg_i   (cfg_wr_clks_i),
        .ale_len_o  (ale_len),
        .strb_len_o (strb_len)
    );

    mxbus_seq #(
        .LOW_W         (LOW_W),
        .DW            (DW),
        .CW            (CW),
        .ON_CHIP_LIMIT (ON_CHIP_LIMIT)
    ) u_seq (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .boot_i       (boot_q),
        .stall_i      (stall_s),
        .req_valid_i  (req_valid_i),
        .req_kind_i   (xfer_kind_e'(req_kind_i)),
        .req_addr_i   (req_addr_i),
        .req_wdata_i  (req_wdata_i),
        .req_be_i     (req_be_i),
        .ale_len_i    (ale_len),
        .strb_len_i   (strb_len),
        .ad_i         (bus_ad_i),
        .int_rdata_i  (int_rdata_i),
        .kind_o       (cur_kind),
        .ready_o      (req_ready_o),
        .resp_valid_o (resp_valid_o),
        .resp_rdata_o (resp_rdata_o),
        .int_rd_o     (int_rd_o),
        .int_addr_o   (int_addr_o),
        .alatch_o     (bus_alatch_o),
        .alo_o        (bus_alo_o),
        .ad_o         (bus_ad_o),
        .ad_oe_o      (bus_ad_oe_o),
        .strobe_o     (stb)
    );

    assign bus_fetch_n_o = ~stb.code;
    assign bus_read_n_o  = ~stb.rd;
    assign bus_wlo_n_o   = ~stb.wlo;
    assign bus_whi_n_o   = ~stb.whi;
endmodule

// File: rtl/mxbus_ctrl_chk.sv
module mxbus_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic ready,
    input logic resp_valid,
    input logic ale,
    input logic oe,
    input logic fetch_n,
    input logic read_n,
    input logic wlo_n,
    input logic whi_n,
    input logic int_rd,
    input logic boot_q
);
    logic any_stb;
    logic rd_type;
    logic wr_type;
    assign rd_type = !fetch_n || !read_n;
    assign wr_type = !wlo_n || !whi_n;
    assign any_stb = rd_type || wr_type;

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
        ready |-> (!ale && !any_stb && !oe)) else $error("ready while bus busy"); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid) else $error("completion longer than one clock"); // R2

    AST_ALE_NO_STB: assert property (@(posedge clk) disable iff (rst)
        ale |-> (!any_stb && oe)) else $error("strobe or release during address phase"); // R3

    AST_STB_AFTER_ALE: assert property (@(posedge clk) disable iff (rst)
        $rose(any_stb) |-> $past(ale)) else $error("strobe not preceded by address phase"); // R3

    AST_ONE_TYPE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!fetch_n, !read_n, wr_type})) else $error("mixed strobe types"); // R4

    AST_WR_DRIVE: assert property (@(posedge clk) disable iff (rst)
        wr_type |-> oe) else $error("write strobe with lines released"); // R6

    AST_RD_RELEASE: assert property (@(posedge clk) disable iff (rst)
        rd_type |-> !oe) else $error("read strobe with lines driven"); // R6

    AST_DONE_NOT_AFTER_ALE: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !$past(ale)) else $error("completion straight after address phase"); // R7

    AST_BOOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(boot_q)) else $error("boot mode changed outside reset"); // R10

    AST_INT_QUIET: assert property (@(posedge clk) disable iff (rst)
        int_rd |-> (!ale && !any_stb && !oe)) else $error("bus activity on internal fetch"); // R11
endmodule

bind mxbus_ctrl mxbus_ctrl_chk u_chk (
    .clk        (clk_i),
    .rst        (rst_i),
    .ready      (req_ready_o),
    .resp_valid (resp_valid_o),
    .ale        (bus_alatch_o),
    .oe         (bus_ad_oe_o),
    .fetch_n    (bus_fetch_n_o),
    .read_n     (bus_read_n_o),
    .wlo_n      (bus_wlo_n_o),
    .whi_n      (bus_whi_n_o),
    .int_rd     (int_rd_o),
    .boot_q     (boot_q)
);

// File: tb/mxbus_ctrl_test.sv
module mxbus_ctrl_test;
    localparam int LOW_W = 4;
    localparam int DW    = 16;
    localparam int CW    = 4;
    localparam int AW    = DW + LOW_W;
    localparam int LIMIT = 32'h0000_4000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst;
    logic              req_valid;
    logic              req_ready;
    logic [1:0]        req_kind;
    logic [AW-1:0]     req_addr;
    logic [DW-1:0]     req_wdata;
    logic [1:0]        req_be;
    logic              resp_valid;
    logic [DW-1:0]     resp_rdata;
    logic [CW-1:0]     cfg_ale, cfg_code, cfg_rd, cfg_wr;
    logic              boot_pin;
    logic              int_rd;
    logic [AW-1:0]     int_addr;
    logic [DW-1:0]     int_rdata;
    logic              alatch;
    logic [LOW_W-1:0]  alo;
    logic [DW-1:0]     ad_o;
    logic              ad_oe;
    logic [DW-1:0]     ad_i;
    logic              stall;
    logic              fetch_n, read_n, wlo_n, whi_n;

    mxbus_ctrl uut (
        .clk_i(clk), .rst_i(rst),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_kind_i(req_kind), .req_addr_i(req_addr),
        .req_wdata_i(req_wdata), .req_be_i(req_be),
        .resp_valid_o(resp_valid), .resp_rdata_o(resp_rdata),
        .cfg_ale_clks_i(cfg_ale), .cfg_code_clks_i(cfg_code),
        .cfg_rd_clks_i(cfg_rd), .cfg_wr_clks_i(cfg_wr),
        .boot_pin_i(boot_pin),
        .int_rd_o(int_rd), .int_addr_o(int_addr), .int_rdata_i(int_rdata),
        .bus_alatch_o(alatch), .bus_alo_o(alo),
        .bus_ad_o(ad_o), .bus_ad_oe_o(ad_oe), .bus_ad_i(ad_i),
        .bus_stall_i(stall),
        .bus_fetch_n_o(fetch_n), .bus_read_n_o(read_n),
        .bus_wlo_n_o(wlo_n), .bus_whi_n_o(whi_n)
    );

    // External memory model: transparent latch plus address-derived data.
    function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
        return (a[15:0] * 16'd3) ^ {12'h000, a[19:16]} ^ 16'hA5C3;
    endfunction

    logic [DW-1:0] lat_q = '0;
    always @(posedge clk) if (alatch) lat_q <= ad_o;
    assign ad_i      = mem_fn({lat_q, alo});
    assign int_rdata = ~mem_fn(int_addr);

    int n_chk = 0;
    int n_bad = 0;
    bit boot_exp;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
        report();
        $finish;
    end

    function automatic int eff(input logic [CW-1:0] v);
        return (v == '0) ? 1 : int'(v);
    endfunction

    task automatic do_reset(input bit boot);
        @(negedge clk);
        rst = 1'b1;
        boot_pin = boot;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        boot_exp = boot;
        // R10: pin flips after reset must be ignored
        boot_pin = ~boot;
        @(negedge clk);
    endtask

    // Starts and ends on a falling edge.
    task automatic run_xfer(input logic [1:0] kind, input logic [AW-1:0] addr,
                            input logic [DW-1:0] wd, input logic [1:0] be);
        bit is_int;
        int a_len, s_len, cyc, exp_cyc;
        logic [3:0] pat, stb_act, stb_exp;
        bit exp_ale, exp_stb, exp_oe, wr;
        wr     = (kind == 2'd2);
        is_int = (kind == 2'd0) && boot_exp && (32'(addr) < LIMIT);
        a_len  = eff(cfg_ale);
        s_len  = (kind == 2'd0) ? eff(cfg_code) : (wr ? eff(cfg_wr) : eff(cfg_rd));
        pat    = (kind == 2'd0) ? 4'b1000 : (wr ? {2'b00, be[0], be[1]} : 4'b0100);
        exp_cyc = is_int ? 2 : a_len + s_len + 1;

        chk(req_ready == 1'b1, "R2 ready before request", 32'(req_ready), 1);
        req_valid = 1'b1;
        req_kind  = kind;
        req_addr  = addr;
        req_wdata = wd;
        req_be    = be;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!resp_valid && cyc < 64) begin
            exp_ale = !is_int && (cyc <= a_len);
            exp_stb = !is_int && (cyc > a_len) && (cyc <= a_len + s_len);
            exp_oe  = exp_ale || (exp_stb && wr);
            stb_act = {~fetch_n, ~read_n, ~wlo_n, ~whi_n};
            stb_exp = exp_stb ? pat : 4'b0000;
            chk(alatch == exp_ale, "R3 latch enable window", 32'(alatch), 32'(exp_ale));
            chk(stb_act == stb_exp, "R4 R5 strobe pattern", 32'(stb_act), 32'(stb_exp));
            chk(ad_oe == exp_oe, "R6 shared line direction", 32'(ad_oe), 32'(exp_oe));
            if (exp_ale)
                chk(ad_o == addr[AW-1:LOW_W], "R3 address on shared lines", 32'(ad_o), 32'(addr[AW-1:LOW_W]));
            if (exp_stb && wr)
                chk(ad_o == wd, "R6 write data on shared lines", 32'(ad_o), 32'(wd));
            if (!is_int)
                chk(alo == addr[LOW_W-1:0], "R8 low address lines", 32'(alo), 32'(addr[LOW_W-1:0]));
            chk(req_ready == 1'b0, "R2 ready low while busy", 32'(req_ready), 0);
            chk(int_rd == (is_int && cyc == 1), "R11 internal read pulse", 32'(int_rd), 32'(is_int && cyc == 1));
            if (is_int && cyc == 1)
                chk(int_addr == addr, "R11 internal address", 32'(int_addr), 32'(addr));
            cyc++;
            @(negedge clk);
        end
        chk(cyc == exp_cyc, is_int ? "R11 internal completion clock" : "R5 completion clock",
            32'(cyc), 32'(exp_cyc));
        chk(req_ready == 1'b1, "R2 ready with completion", 32'(req_ready), 1);
        if (!wr) begin
            if (is_int)
                chk(resp_rdata == ~mem_fn(addr), "R11 internal read data", 32'(resp_rdata), 32'(~mem_fn(addr)));
            else
                chk(resp_rdata == mem_fn(addr), "R7 read data", 32'(resp_rdata), 32'(mem_fn(addr)));
        end
        @(negedge clk);
        chk(resp_valid == 1'b0, "R2 single completion pulse", 32'(resp_valid), 0);
        if (!is_int)
            chk(alo == addr[LOW_W-1:0], "R8 low address held idle", 32'(alo), 32'(addr[LOW_W-1:0]));
    endtask

    initial begin
        int unsigned sd;
        rst = 1'b1; req_valid = 1'b0; req_kind = '0; req_addr = '0; req_wdata = '0;
        req_be = '0; boot_pin = 1'b1; stall = 1'b0;
        cfg_ale = 4'd1; cfg_code = 4'd1; cfg_rd = 4'd2; cfg_wr = 4'd3;
        sd = $urandom(32'd13579);

        // R1: values while reset is held
        repeat (2) @(negedge clk);
        chk(alatch == 1'b0, "R1 latch enable in reset", 32'(alatch), 0);
        chk({fetch_n, read_n, wlo_n, whi_n} == 4'hF, "R1 strobes in reset",
            32'({fetch_n, read_n, wlo_n, whi_n}), 32'hF);
        chk(ad_oe == 1'b0, "R1 output enable in reset", 32'(ad_oe), 0);
        do_reset(1'b1);
        chk(req_ready == 1'b1 && resp_valid == 1'b0, "R1 handshake after reset",
            32'({req_ready, resp_valid}), 32'h2);
        chk(alo == '0, "R1 low address after reset", 32'(alo), 0);

        // R10/R11: boot captured high, pin now low; limit boundary
        run_xfer(2'd0, 20'(LIMIT - 1), '0, 2'b00);
        run_xfer(2'd0, 20'(LIMIT), '0, 2'b00);
        run_xfer(2'd1, 20'h00010, '0, 2'b00);

        // R4: byte enables
        run_xfer(2'd2, 20'h5A5A1, 16'hBEEF, 2'b11);
        run_xfer(2'd2, 20'h12342, 16'h1111, 2'b01);
        run_xfer(2'd2, 20'h12343, 16'h2222, 2'b10);

        // R5: zero counts act as one clock; largest counts
        cfg_ale = 4'd0; cfg_code = 4'd0; cfg_rd = 4'd0; cfg_wr = 4'd0;
        run_xfer(2'd1, 20'hABCDE, '0, 2'b00);
        run_xfer(2'd0, 20'hFFFFF, '0, 2'b00);
        run_xfer(2'd2, 20'h4000F, 16'h0F0F, 2'b11);
        cfg_ale = 4'd15; cfg_code = 4'd15; cfg_rd = 4'd15; cfg_wr = 4'd15;
        run_xfer(2'd1, 20'h54321, '0, 2'b00);
        run_xfer(2'd2, 20'h54320, 16'hC3C3, 2'b11);

        // R9: stall held past the programmed strobe, then released
        cfg_ale = 4'd1; cfg_rd = 4'd2;
        stall = 1'b1;
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd1; req_addr = 20'h9876A; req_be = 2'b00;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (9) @(negedge clk);
        chk(read_n == 1'b0 && resp_valid == 1'b0, "R9 strobe held by stall",
            32'({read_n, resp_valid}), 0);
        stall = 1'b0;
        @(negedge clk);
        chk(read_n == 1'b0, "R9 strobe after release edge", 32'(read_n), 0);
        @(negedge clk);
        chk(read_n == 1'b0 && resp_valid == 1'b0, "R9 strobe one clock later",
            32'({read_n, resp_valid}), 0);
        @(negedge clk);
        chk(read_n == 1'b1 && resp_valid == 1'b1, "R9 completion after sync delay",
            32'({read_n, resp_valid}), 32'h3);
        chk(resp_rdata == mem_fn(20'h9876A), "R9 R7 read data after stall",
            32'(resp_rdata), 32'(mem_fn(20'h9876A)));
        @(negedge clk);

        // Random traffic with boot mode high
        for (int i = 0; i < 120; i++) begin
            logic [1:0] k;
            logic [AW-1:0] a;
            if (i % 20 == 0) begin
                cfg_ale  = 4'($urandom_range(0, 5));
                cfg_code = 4'($urandom_range(0, 5));
                cfg_rd   = 4'($urandom_range(0, 5));
                cfg_wr   = 4'($urandom_range(0, 5));
            end
            k = 2'($urandom_range(0, 2));
            a = 20'($urandom);
            if ($urandom_range(0, 1) == 1) a = 20'(a % LIMIT);
            run_xfer(k, a, 16'($urandom), 2'($urandom_range(1, 3)));
        end

        // R10/R11: boot captured low, pin now high; every fetch external
        do_reset(1'b0);
        run_xfer(2'd0, 20'h00000, '0, 2'b00);
        run_xfer(2'd0, 20'(LIMIT - 1), '0, 2'b00);
        for (int i = 0; i < 30; i++)
            run_xfer(2'($urandom_range(0, 2)), 20'($urandom % LIMIT), 16'($urandom),
                     2'($urandom_range(1, 3)));

        report();
        $finish;
    end
endmodule